// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block keeps instructions in program order between decode and retirement in an out-of-order core. Decode claims a slot for each instruction and receives a slot tag. The writeback bus marks slots finished in any order and carries each result, an exception flag and a resolved-branch outcome. The oldest slot retires once it is finished. It writes its result to the architectural register file or releases its store to memory, so effects outside the core follow program order.

If the oldest slot holds a faulting instruction, nothing from it or from any younger slot reaches the register file or memory. The block empties itself, records the faulting PC, and steers fetch to a fixed handler address. A taken branch that reaches retirement also empties the younger slots and steers fetch to its target, but it keeps the saved exception PC. The flush pulse tells the rename file to return to committed state and tells the functional units to drop cached work.

Top module: `rob_top`

## Requirements
- R1: Each accepted allocation (alloc_valid and alloc_ready high at a clock edge) gets the tag shown on alloc_tag in that cycle. alloc_ready is low while DEPTH slots are occupied.
- R2: Completions may arrive in any order. At most one slot retires per cycle, always the oldest, and only after its completion has been recorded.
- R3: A retiring non-faulting slot drives rf_we with its destination and result in the cycle after its completion is registered. Destination 0 means no register write.
- R4: A store drives st_release with its tag only when it retires. A finished store waits behind older unfinished slots.
- R5: A faulting slot at the head raises flush and redirect_valid with redirect_pc = 0x1100 (HANDLER_PC). In that cycle it produces neither a register write nor a store release.
- R6: A faulting retirement loads its PC into epc. The next cycle epc shows it. Nothing else changes epc.
- R7: A flush drops every slot and resets both pointers to slot 0. No younger slot ever writes a register or releases a store.
- R8: A taken branch at the head retires normally, including its register write, and raises flush with redirect_pc equal to its target. epc is unchanged.
- R9: During a flush cycle alloc_ready is low and an allocation request is ignored.
- R10: Tags and pointers wrap from DEPTH-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_pc | input | XLEN | PC of the instruction being allocated |
| alloc_dest | input | RW | Destination register, 0 for none |
| alloc_store | input | 1 | Instruction is a store |
| alloc_ready | output | 1 | Slot available and no flush this cycle |
| alloc_tag | output | TW | Tag given to the allocation |
| wb_valid | input | 1 | Writeback bus carries a completion |
| wb_tag | input | TW | Slot being completed |
| wb_value | input | XLEN | Result value |
| wb_exc | input | 1 | Instruction faulted |
| wb_taken | input | 1 | Branch resolved taken |
| wb_target | input | XLEN | Taken-branch target |
| rf_we | output | 1 | Architectural register write |
| rf_addr | output | RW | Register written |
| rf_data | output | XLEN | Value written |
| st_release | output | 1 | Store may be performed |
| st_tag | output | TW | Tag of the released store |
| flush | output | 1 | Discard all speculative state |
| redirect_valid | output | 1 | Fetch must restart |
| redirect_pc | output | XLEN | Fetch restart address |
| epc | output | XLEN | Saved PC of last faulting instruction |

## Verification
The hardest case to reach is a flush while younger slots are already finished and ready to retire. If one of them got through, it would show as a stray register write or store release right after the redirect. The stimulus completes the younger slots, including a store, before the faulting or branching head is finished. It then completes the head last, so the flush and the would-be retirements line up on consecutive cycles. A second hard case is the full buffer: the bench fills all slots from a non-zero head so the pointers wrap, offers an allocation while full, and drains through completions issued one per cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
   parameter int XLEN = 32;
   parameter int RW   = 5;

   typedef struct packed {
      logic            valid;
      logic            done;
      logic            exc;
      logic            taken;
      logic            store;
      logic [RW-1:0]   dest;
      logic [XLEN-1:0] pc;
      logic [XLEN-1:0] value;
      logic [XLEN-1:0] target;
   } slot_t;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
   parameter int DEPTH = 8,
   parameter int W     = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         clr,
   output logic [W-1:0] ptr
);
   logic [W-1:0] nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign nxt = ptr + 1'b1;
      end else begin : g_mod
         assign nxt = (ptr == W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) ptr <= '0;
      else if (adv)      ptr <= nxt;
   end

   // R10: pointer never leaves the slot range
   a_r10_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= W'(DEPTH - 1));
   // R10: advancing without clear moves the pointer
   a_r10_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |=> ptr != $past(ptr));
endmodule

// File: rtl/rob_slots.sv
module rob_slots
   import rob_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int TW    = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            alloc_en,
   input  logic [TW-1:0]   alloc_idx,
   input  logic [XLEN-1:0] alloc_pc,
   input  logic [RW-1:0]   alloc_dest,
   input  logic            alloc_store,
   input  logic            wb_en,
   input  logic [TW-1:0]   wb_idx,
   input  logic [XLEN-1:0] wb_value,
   input  logic            wb_exc,
   input  logic            wb_taken,
   input  logic [XLEN-1:0] wb_target,
   input  logic            retire_en,
   input  logic [TW-1:0]   head_idx,
   output slot_t           head
);
   slot_t mem [DEPTH];

   assign head = mem[head_idx];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               mem[i] <= '0;
            end else if (alloc_en && alloc_idx == TW'(i)) begin
               mem[i].valid  <= 1'b1;
               mem[i].done   <= 1'b0;
               mem[i].exc    <= 1'b0;
               mem[i].taken  <= 1'b0;
               mem[i].store  <= alloc_store;
               mem[i].dest   <= alloc_dest;
               mem[i].pc     <= alloc_pc;
               mem[i].value  <= '0;
               mem[i].target <= '0;
            end else if (retire_en && head_idx == TW'(i)) begin
               mem[i].valid <= 1'b0;
               mem[i].done  <= 1'b0;
            end else if (wb_en && wb_idx == TW'(i) && mem[i].valid) begin
               mem[i].done   <= 1'b1;
               mem[i].value  <= wb_value;
               mem[i].exc    <= wb_exc;
               mem[i].taken  <= wb_taken;
               mem[i].target <= wb_target;
            end
         end
      end
   endgenerate

   // R2: the head only retires once finished
   a_r2_retire_done: assert property (@(posedge clk) disable iff (!rst_n)
      retire_en |-> (head.valid && head.done));
endmodule

// File: rtl/rob_top.sv
module rob_top
   import rob_pkg::*;
#(
   parameter int          DEPTH      = 8,
   parameter logic [31:0] HANDLER_PC = 32'h0000_1100,
   localparam int         TW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_valid,
   input  logic [XLEN-1:0] alloc_pc,
   input  logic [RW-1:0]   alloc_dest,
   input  logic            alloc_store,
   output logic            alloc_ready,
   output logic [TW-1:0]   alloc_tag,
   input  logic            wb_valid,
   input  logic [TW-1:0]   wb_tag,
   input  logic [XLEN-1:0] wb_value,
   input  logic            wb_exc,
   input  logic            wb_taken,
   input  logic [XLEN-1:0] wb_target,
   output logic            rf_we,
   output logic [RW-1:0]   rf_addr,
   output logic [XLEN-1:0] rf_data,
   output logic            st_release,
   output logic [TW-1:0]   st_tag,
   output logic            flush,
   output logic            redirect_valid,
   output logic [XLEN-1:0] redirect_pc,
   output logic [XLEN-1:0] epc
);
   localparam int CW = TW + 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rob_top: DEPTH must be at least 2");
      end
      if (XLEN < 16) begin : g_bad_xlen
         $error("rob_top: XLEN too small for handler address");
      end
   endgenerate

   logic [TW-1:0] head_idx, tail_idx;
   logic [CW-1:0] count;
   slot_t         head;
   logic          retire, fault, take, alloc_go;

   assign retire   = head.valid && head.done;
   assign fault    = retire && head.exc;
   assign take     = retire && !head.exc && head.taken;
   assign flush    = fault || take;

   assign alloc_ready = (count != CW'(DEPTH)) && !flush;
   assign alloc_go    = alloc_valid && alloc_ready;
   assign alloc_tag   = tail_idx;

   assign rf_we      = retire && !head.exc && (head.dest != '0);
   assign rf_addr    = head.dest;
   assign rf_data    = head.value;
   assign st_release = retire && !head.exc && head.store;
   assign st_tag     = head_idx;

   assign redirect_valid = flush;
   assign redirect_pc    = fault ? XLEN'(HANDLER_PC) : head.target;

   rob_ptr #(.DEPTH(DEPTH), .W(TW)) u_head (
      .clk(clk), .rst_n(rst_n), .adv(retire), .clr(flush), .ptr(head_idx));
   rob_ptr #(.DEPTH(DEPTH), .W(TW)) u_tail (
      .clk(clk), .rst_n(rst_n), .adv(alloc_go), .clr(flush), .ptr(tail_idx));

   rob_slots #(.DEPTH(DEPTH), .TW(TW)) u_slots (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .alloc_en(alloc_go), .alloc_idx(tail_idx), .alloc_pc(alloc_pc),
      .alloc_dest(alloc_dest), .alloc_store(alloc_store),
      .wb_en(wb_valid), .wb_idx(wb_tag), .wb_value(wb_value),
      .wb_exc(wb_exc), .wb_taken(wb_taken), .wb_target(wb_target),
      .retire_en(retire), .head_idx(head_idx), .head(head));

   always_ff @(posedge clk) begin
      if (!rst_n || flush)
         count <= '0;
      else
         count <= count + CW'(alloc_go) - CW'(retire);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     epc <= '0;
      else if (fault) epc <= head.pc;
   end

   // R1: occupancy never exceeds the slot count
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R5: a faulting retirement has no visible effect
   a_r5_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!rf_we && !st_release && redirect_pc == XLEN'(HANDLER_PC)));
   // R6: epc is only loaded by a faulting retirement
   a_r6_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |=> $stable(epc));
   // R7: a flush empties the buffer
   a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0 && head_idx == '0 && tail_idx == '0));
   // R9: no allocation accepted while flushing
   a_r9_no_alloc_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !alloc_ready);
endmodule

// File: tb/sim_rob_top.sv
module sim_rob_top;
   localparam int DEPTH = 8;
   localparam int TW = 3;

   logic clk = 0, rst_n = 0;
   logic alloc_valid = 0, alloc_store = 0;
   logic [31:0] alloc_pc = 0;
   logic [4:0] alloc_dest = 0;
   logic alloc_ready;
   logic [TW-1:0] alloc_tag;
   logic wb_valid = 0, wb_exc = 0, wb_taken = 0;
   logic [TW-1:0] wb_tag = 0;
   logic [31:0] wb_value = 0, wb_target = 0;
   logic rf_we, st_release, flush, redirect_valid;
   logic [4:0] rf_addr;
   logic [31:0] rf_data, redirect_pc, epc;
   logic [TW-1:0] st_tag;

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   rob_top #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_pc(alloc_pc),
      .alloc_dest(alloc_dest), .alloc_store(alloc_store), .alloc_ready(alloc_ready),
      .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
      .wb_value(wb_value), .wb_exc(wb_exc), .wb_taken(wb_taken),
      .wb_target(wb_target), .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
      .st_release(st_release), .st_tag(st_tag), .flush(flush),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .epc(epc));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic alloc(input logic [31:0] pc, input logic [4:0] dest, input logic st);
      alloc_valid = 1; alloc_pc = pc; alloc_dest = dest; alloc_store = st;
      tick();
      alloc_valid = 0; alloc_store = 0; alloc_dest = 0;
   endtask

   task automatic wb(input logic [TW-1:0] tag, input logic [31:0] val,
                     input logic exc, input logic tk, input logic [31:0] tgt);
      wb_valid = 1; wb_tag = tag; wb_value = val; wb_exc = exc; wb_taken = tk; wb_target = tgt;
      tick();
      wb_valid = 0; wb_exc = 0; wb_taken = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset ready", alloc_ready, 1);
      chk("R1 reset tag", alloc_tag, 0);
      chk("R3 reset rf_we", rf_we, 0);
      chk("R5 reset redirect", redirect_valid, 0);
      chk("R6 reset epc", epc, 0);
   endtask

   task automatic t_order();
      chk("R1 first tag", alloc_tag, 0);
      alloc(32'h10, 5'd1, 0);
      chk("R1 second tag", alloc_tag, 1);
      alloc(32'h14, 5'd2, 0);
      alloc(32'h18, 5'd3, 0);
      wb(2, 32'hC, 0, 0, 0);
      wb(1, 32'hB, 0, 0, 0);
      chk("R2 no retire before head done", rf_we, 0);
      wb(0, 32'hA, 0, 0, 0);
      chk("R3 write 1", rf_we, 1);
      chk("R3 addr 1", rf_addr, 1);
      chk("R3 data 1", rf_data, 32'hA);
      tick();
      chk("R2 second retire addr", rf_addr, 2);
      chk("R2 second retire we", rf_we, 1);
      tick();
      chk("R2 third retire addr", rf_addr, 3);
      chk("R3 third data", rf_data, 32'hC);
      tick();
      chk("R2 idle after drain", rf_we, 0);
   endtask

   task automatic t_full_wrap();
      chk("R10 tag before fill", alloc_tag, 3);
      for (int i = 0; i < DEPTH; i++) alloc(32'h100 + i, 5'd7, 0);
      chk("R1 full ready low", alloc_ready, 0);
      alloc(32'hDEAD, 5'd9, 0);
      chk("R1 still full", alloc_ready, 0);
      for (int i = 0; i < DEPTH; i++) wb(TW'(3 + i), i, 0, 0, 0);
      tick();
      chk("R1 ready after drain", alloc_ready, 1);
      chk("R10 tag wrapped", alloc_tag, 3);
      chk("R3 dest0 silent", rf_we, 0);
   endtask

   task automatic t_store();
      alloc(32'h20, 5'd8, 0);
      alloc(32'h24, 5'd0, 1);
      wb(4, 0, 0, 0, 0);
      chk("R4 store waits for older", st_release, 0);
      wb(3, 32'h55, 0, 0, 0);
      chk("R4 older retires first", rf_addr, 8);
      chk("R4 no release with older", st_release, 0);
      tick();
      chk("R4 store released", st_release, 1);
      chk("R4 store tag", st_tag, 4);
      chk("R3 store no write", rf_we, 0);
      tick();
   endtask

   task automatic t_fault();
      alloc(32'h1FC, 5'd4, 0);
      alloc(32'h200, 5'd9, 0);
      alloc(32'h204, 5'd5, 0);
      alloc(32'h208, 5'd0, 1);
      wb(7, 1, 0, 0, 0);
      wb(0, 2, 0, 0, 0);
      wb(6, 3, 1, 0, 0);
      wb(5, 4, 0, 0, 0);
      chk("R5 older commits", rf_addr, 4);
      chk("R5 older we", rf_we, 1);
      chk("R5 no early redirect", redirect_valid, 0);
      tick();
      chk("R5 redirect", redirect_valid, 1);
      chk("R5 handler pc", redirect_pc, 32'h1100);
      chk("R5 no write", rf_we, 0);
      chk("R5 no release", st_release, 0);
      chk("R9 ready low in flush", alloc_ready, 0);
      alloc_valid = 1; alloc_pc = 32'h999;
      tick();
      alloc_valid = 0;
      chk("R6 epc saved", epc, 32'h200);
      chk("R7 pointers reset", alloc_tag, 0);
      chk("R9 alloc ignored", alloc_tag, 0);
      chk("R7 younger no write", rf_we, 0);
      chk("R7 younger no store", st_release, 0);
      tick();
      chk("R7 still quiet", rf_we | st_release, 0);
   endtask

   task automatic t_branch();
      alloc(32'h300, 5'd10, 0);
      alloc(32'h304, 5'd6, 0);
      wb(1, 7, 0, 0, 0);
      wb(0, 32'h77, 0, 1, 32'h400);
      chk("R8 redirect", redirect_valid, 1);
      chk("R8 target", redirect_pc, 32'h400);
      chk("R8 own write", rf_we, 1);
      chk("R8 own addr", rf_addr, 10);
      tick();
      chk("R8 epc unchanged", epc, 32'h200);
      chk("R7 branch flush tag", alloc_tag, 0);
      chk("R7 younger dropped", rf_we, 0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_order();
      t_full_wrap();
      t_store();
      t_fault();
      t_branch();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule